// File: doc/BRIEF.md
# Wakeup Pin Edge Filter

This block watches sixteen external wakeup pins. One pin, picked at run time, is taken through a synchronizer and a digital glitch filter. The filtered level is then checked for the kind of edge that software has set up. If a qualifying edge arrives while the chip is in low-power mode, the block sets a sticky detect flag and drives a wakeup request toward the power controller. The request stays high until software clears the flag.

Software reaches all of it through one byte-wide control and status register. Bit 7 is the detect flag, cleared by writing a one. Bits 6:5 give the edge mode (00 off, 01 rising, 10 falling, 11 any). Bit 4 is reserved. Bits 3:0 give the pin index. The register sits in the full-chip reset domain, so the lighter low-power-exit reset leaves the flag and the configuration intact. That reset only restarts the filter datapath. The register port is plain control: a write strobe with data, and combinational read data. Nothing on the block flows as a stream, so there is no valid/ready and no back-pressure.

Top module: `wake_pin_filter`

## Requirements
- R1: After chip reset, the register reads 8'h00 and wake_req is 0.
- R2: A write stores bits 6:5 as the edge mode and bits 3:0 as the pin index, and both read back unchanged. Bit 4 always reads 0, even after a one is written to it. Without a write, the configuration does not change.
- R3: In rising mode (01), when the selected pin goes from 0 to 1 and stays high, the flag (bit 7) and wake_req go to 1. A falling edge in this mode sets nothing.
- R4: In falling mode (10), a 1-to-0 transition of the selected pin sets the flag. A 0-to-1 transition sets nothing.
- R5: In any-edge mode (11), both a rising and a falling transition of the selected pin set the flag.
- R6: A new level counts only after it has been seen for 5 consecutive clock cycles past the 2-flop synchronizer. A pulse of 4 cycles sets nothing. A pulse of 5 cycles is detected.
- R7: The flag is set only while lp_mode is 1. An edge seen while lp_mode is 0 is lost; it is not reported later.
- R8: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged. wake_req always equals the flag.
- R9: If a detection and a write of 1 to bit 7 happen in the same cycle, the flag ends up 1.
- R10: In mode 00, no transition of the selected pin sets the flag.
- R11: Only the selected pin matters. Changing the pin index or the edge mode restarts the filter, and the switch itself never reports an edge, even when the old and new pins differ in level.
- R12: Pulsing lp_rst_n low leaves the register value unchanged. chip_rst_n returns it to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter and register clock |
| chip_rst_n | input | 1 | Full chip reset, active low, asynchronous; resets everything |
| lp_rst_n | input | 1 | Low-power-exit reset, active low; restarts the filter only |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data {flag, mode[1:0], 0, pin[3:0]} |
| wake_pins | input | 16 | External wakeup pins, asynchronous |
| lp_mode | input | 1 | High while the chip is in low-power mode |
| wake_req | output | 1 | Wakeup request, equal to the detect flag |

## Verification
Two things can land on the same clock edge: the filter completing an edge detection, and software writing 1 to clear the flag. The bench drives the selected pin high on a falling clock edge. It counts two synchronizer cycles and five filter cycles. It then places the clearing write so that it is sampled on the same rising edge that the detection sets the flag. The flag must then read 1 (set wins). A second clearing write one cycle later must bring it to 0, which shows that the first write really did fall in the detection cycle.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 4;
  localparam int NUM_PINS = 2 ** SEL_W;
  localparam int FLAG_BIT = 7;
  localparam int MODE_LSB = 5;
  localparam int RSVD_BIT = 4;
  localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1) << RSVD_BIT;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/wpf_pin_sync.sv
module wpf_pin_sync
  import wpf_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [SEL_W-1:0]    sel,
  output logic                sync_lvl
);
  logic picked;
  logic [STAGES-1:0] chain;

  always_comb picked = pins[sel];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= picked;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_lvl = chain[STAGES-1];
endmodule

// File: rtl/wpf_edge_filter.sv
module wpf_edge_filter
  import wpf_pkg::*;
#(
  parameter int FILT_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_lvl,
  input  edge_mode_e mode,
  input  logic       restart,
  output logic       hit
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic          run_val;
  logic [CW-1:0] run_cnt;
  logic          filt_lvl;
  logic          primed;
  logic          accept;
  logic          pol_ok;

  always_comb begin
    accept = (mode != EDGE_OFF) && !restart && (sync_lvl == run_val) && (run_cnt == LAST);
    case (mode)
      EDGE_RISE: pol_ok = run_val;
      EDGE_FALL: pol_ok = !run_val;
      EDGE_ANY:  pol_ok = 1'b1;
      default:   pol_ok = 1'b0;
    endcase
    hit = accept && primed && (run_val != filt_lvl) && pol_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_val  <= 1'b0;
      run_cnt  <= '0;
      filt_lvl <= 1'b0;
      primed   <= 1'b0;
    end else if (restart) begin
      run_cnt <= '0;
      primed  <= 1'b0;
    end else if (mode != EDGE_OFF) begin
      if (sync_lvl == run_val) begin
        if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_val <= sync_lvl;
        run_cnt <= CW'(1);
      end
      if (accept) begin
        filt_lvl <= run_val;
        primed   <= 1'b1;
      end
    end
  end

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF && !restart) |=> ($stable(run_cnt) && $stable(filt_lvl) && !hit)); // R10
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !hit); // R11
  AST_HIT_STABLE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(sync_lvl) == sync_lvl)); // R6
endmodule

// File: rtl/wpf_ctrl_reg.sv
module wpf_ctrl_reg
  import wpf_pkg::*;
(
  input  logic             clk,
  input  logic             chip_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             lp_mode,
  input  logic             hit,
  output logic             flag,
  output edge_mode_e       mode,
  output logic [SEL_W-1:0] sel,
  output logic             cfg_chg,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] wval;
  logic [6:0]       cur;
  logic             set_req;

  always_comb begin
    wval    = wdata & ~RSVD_MASK;
    cur     = {mode, 1'b0, sel};
    cfg_chg = wr_en && (wval[6:0] != cur);
    set_req = hit && lp_mode;
    rdata   = {flag, mode, 1'b0, sel};
  end

  always_ff @(posedge clk or negedge chip_rst_n) begin
    if (!chip_rst_n) begin
      flag <= 1'b0;
      mode <= EDGE_OFF;
      sel  <= '0;
    end else begin
      if (wr_en) begin
        mode <= edge_mode_e'(wval[MODE_LSB+1:MODE_LSB]);
        sel  <= wval[SEL_W-1:0];
      end
      if (set_req)                    flag <= 1'b1;
      else if (wr_en && wval[FLAG_BIT]) flag <= 1'b0;
    end
  end

  AST_NO_SET_AWAKE: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (!flag && !lp_mode) |=> !flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (flag && !(wr_en && wdata[FLAG_BIT])) |=> flag); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (wr_en && wdata[FLAG_BIT] && !set_req) |=> !flag); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!chip_rst_n)
    set_req |=> flag); // R9
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!chip_rst_n)
    !wr_en |=> $stable(rdata[6:0])); // R2
endmodule

// File: rtl/wake_pin_filter.sv
module wake_pin_filter
  import wpf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 5
) (
  input  logic                clk,
  input  logic                chip_rst_n,
  input  logic                lp_rst_n,
  input  logic                reg_wr_en,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] wake_pins,
  input  logic                lp_mode,
  output logic                wake_req
);
  logic             filt_rst_n;
  logic             sync_lvl;
  logic             hit;
  logic             flag;
  logic             cfg_chg;
  edge_mode_e       mode;
  logic [SEL_W-1:0] sel;

  assign filt_rst_n = chip_rst_n & lp_rst_n;

  wpf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(filt_rst_n), .pins(wake_pins), .sel(sel), .sync_lvl(sync_lvl)
  );

  wpf_edge_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(filt_rst_n), .sync_lvl(sync_lvl), .mode(mode),
    .restart(cfg_chg), .hit(hit)
  );

  wpf_ctrl_reg u_reg (
    .clk(clk), .chip_rst_n(chip_rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .lp_mode(lp_mode), .hit(hit), .flag(flag), .mode(mode), .sel(sel),
    .cfg_chg(cfg_chg), .rdata(reg_rdata)
  );

  assign wake_req = flag;
endmodule

// File: tb/tb_wake_pin_filter.sv
module tb_wake_pin_filter;
  logic        clk = 1'b0;
  logic        chip_rst_n = 1'b0;
  logic        lp_rst_n = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] wake_pins = '0;
  logic        lp_mode = 1'b1;
  logic        wake_req;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_pin_filter dut (
    .clk(clk), .chip_rst_n(chip_rst_n), .lp_rst_n(lp_rst_n),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_pins(wake_pins), .lp_mode(lp_mode), .wake_req(wake_req)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  // mode/pin write with flag clear, then let the filter settle
  task automatic cfg(logic [1:0] m, logic [3:0] p);
    wr({1'b1, m, 1'b0, p});
    cyc(12);
  endtask

  task automatic flag_is(string req, logic e);
    check(req, {7'd0, reg_rdata[7]}, {7'd0, e});
    check(req, {7'd0, wake_req}, {7'd0, e});
  endtask

  task automatic t_reset();
    check("R1", reg_rdata, 8'h00);
    check("R1", {7'd0, wake_req}, 8'h00);
  endtask

  task automatic t_fields();
    wr(8'h7F);
    check("R2", reg_rdata, 8'h6F);
    cyc(3);
    check("R2", reg_rdata, 8'h6F);
    wr(8'h35);
    check("R2", reg_rdata, 8'h25);
  endtask

  task automatic t_rise();
    wake_pins = '0; lp_mode = 1'b1;
    cfg(2'b01, 4'd2);
    wake_pins[2] = 1'b1; cyc(12);
    flag_is("R3", 1'b1);
    wr({1'b1, 2'b01, 1'b0, 4'd2});
    flag_is("R3", 1'b0);
    wake_pins[2] = 1'b0; cyc(12);
    flag_is("R3", 1'b0);
  endtask

  task automatic t_fall();
    wake_pins = '0; wake_pins[7] = 1'b1;
    cfg(2'b10, 4'd7);
    flag_is("R4", 1'b0);
    wake_pins[7] = 1'b0; cyc(12);
    flag_is("R4", 1'b1);
    wr({1'b1, 2'b10, 1'b0, 4'd7});
    wake_pins[7] = 1'b1; cyc(12);
    flag_is("R4", 1'b0);
  endtask

  task automatic t_any();
    wake_pins = '0;
    cfg(2'b11, 4'd9);
    wake_pins[9] = 1'b1; cyc(12);
    flag_is("R5", 1'b1);
    wr({1'b1, 2'b11, 1'b0, 4'd9});
    wake_pins[9] = 1'b0; cyc(12);
    flag_is("R5", 1'b1);
    wr({1'b1, 2'b11, 1'b0, 4'd9});
  endtask

  task automatic t_glitch();
    wake_pins = '0;
    cfg(2'b01, 4'd1);
    wake_pins[1] = 1'b1; cyc(4); wake_pins[1] = 1'b0; cyc(12);
    flag_is("R6", 1'b0);
    wake_pins[1] = 1'b1; cyc(5); wake_pins[1] = 1'b0; cyc(12);
    flag_is("R6", 1'b1);
    wr({1'b1, 2'b01, 1'b0, 4'd1});
  endtask

  task automatic t_nolp();
    wake_pins = '0;
    cfg(2'b01, 4'd11);
    lp_mode = 1'b0;
    wake_pins[11] = 1'b1; cyc(12);
    flag_is("R7", 1'b0);
    lp_mode = 1'b1; cyc(12);
    flag_is("R7", 1'b0);
  endtask

  task automatic t_w1c();
    wake_pins = '0;
    cfg(2'b01, 4'd12);
    wake_pins[12] = 1'b1; cyc(12);
    flag_is("R8", 1'b1);
    wr({1'b0, 2'b01, 1'b0, 4'd12});
    flag_is("R8", 1'b1);
    wr({1'b1, 2'b01, 1'b0, 4'd12});
    flag_is("R8", 1'b0);
  endtask

  task automatic t_collide();
    wake_pins = '0;
    cfg(2'b01, 4'd4);
    @(negedge clk);
    wake_pins[4] = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = {1'b1, 2'b01, 1'b0, 4'd4};
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    flag_is("R9", 1'b1);
    wr({1'b1, 2'b01, 1'b0, 4'd4});
    flag_is("R9", 1'b0);
  endtask

  task automatic t_off();
    wake_pins = '0;
    cfg(2'b00, 4'd6);
    wake_pins[6] = 1'b1; cyc(12);
    flag_is("R10", 1'b0);
    wake_pins[6] = 1'b0; cyc(12);
    flag_is("R10", 1'b0);
    wake_pins[6] = 1'b1; cyc(12);
    wr({1'b0, 2'b01, 1'b0, 4'd6}); cyc(12);
    flag_is("R11", 1'b0);
  endtask

  task automatic t_switch();
    wake_pins = '0; wake_pins[5] = 1'b1;
    cfg(2'b01, 4'd3);
    wake_pins[8] = 1'b1; wake_pins[0] = 1'b1; cyc(12);
    flag_is("R11", 1'b0);
    wr({1'b0, 2'b01, 1'b0, 4'd5}); cyc(15);
    flag_is("R11", 1'b0);
    wr({1'b0, 2'b11, 1'b0, 4'd5}); cyc(15);
    flag_is("R11", 1'b0);
  endtask

  task automatic t_resets();
    wake_pins = '0;
    cfg(2'b11, 4'd10);
    wake_pins[10] = 1'b1; cyc(12);
    check("R12", reg_rdata, 8'hEA);
    lp_rst_n = 1'b0; cyc(3); lp_rst_n = 1'b1; cyc(2);
    check("R12", reg_rdata, 8'hEA);
    chip_rst_n = 1'b0; cyc(2);
    check("R12", reg_rdata, 8'h00);
    chip_rst_n = 1'b1; cyc(2);
    check("R12", {7'd0, wake_req}, 8'h00);
  endtask

  initial begin
    cyc(3);
    t_reset();
    chip_rst_n = 1'b1; cyc(2);
    t_reset();
    t_fields();
    t_rise();
    t_fall();
    t_any();
    t_glitch();
    t_nolp();
    t_w1c();
    t_collide();
    t_off();
    t_switch();
    t_resets();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule